// File: doc/BRIEF.md
# Pipelined ADC Digital Correction Back End

This block is the digital back end of a nine-stage pipelined analog-to-digital converter. On every clock each stage hands it a 2-bit redundant decision. A later stage delivers its decision for a given sample later than an earlier stage does. The block gives each stage a delay line of its own length, so that all nine decisions for one sample meet in the same cycle. It then adds the overlapping decisions, with their binary weights, into one 10-bit word. The sum is clamped at the top code, so an over-range input does not wrap around.

The corrected word is registered onto an output bus. A tri-state pad wrapper outside the block uses the `data_oe_o` output for this bus. An active-low output enable and a power-down input both turn the bus off. A valid flag marks the words that can be used. It stays low for a fixed window of words after reset and after the block leaves power-down, because those words hold samples that the pipeline did not convert correctly.

Top module: `pipe_adc_corr`

## Requirements
- R1: The `stage_code_i` input carries stage k (k = 1..9) in bits [2k-1:2k-2]. For any sample, stage k presents its code floor((k-1)/2) cycles after stage 1 presents its own code.
- R2: Once aligned, the codes d1..d9 of one sample produce the word sum(dk * 2^(9-k)) for k = 1..9. Stage 1 carries weight 256 and stage 9 carries weight 1.
- R3: A sample's word appears on `data_o` right after the 5th rising edge that follows the edge which captured its stage 1 code.
- R4: The output uses straight offset binary. All-zero codes give 0000000000. A stage 1 code of 2 with every other code at 0 gives 1000000000. The code set d1=3, d2..d9=1 gives 1111111111.
- R5: A total above 1023 gives 1023 and never wraps. Examples are all codes at 3, and d1=d2=3 with the rest at 0.
- R6: `data_oe_o` is high exactly when `oe_ni` is low and `pwrdn_i` is low. While `data_oe_o` is low, `data_o` reads all zeros.
- R7: While `pwrdn_i` is high, `data_oe_o` and `data_valid_o` are both low.
- R8: After `pwrdn_i` falls, `data_valid_o` stays low for the words registered on the first 5 rising edges with `pwrdn_i` low. It rises with the word registered on the 6th such edge.
- R9: `rst_ni` is an asynchronous active-low reset. It forces `data_o` to zero and `data_valid_o` low at once and clears the delay lines. After release, the same 5-word invalid window applies as in R8.
- R10: Holding `oe_ni` high only blanks the bus. The pipeline keeps running, so the first word shown after `oe_ni` returns low is the correct word for its sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stage_code_i | input | 18 | Nine 2-bit stage decisions, with stage 1 in the low bits |
| oe_ni | input | 1 | Output enable, active low |
| pwrdn_i | input | 1 | Power-down request, active high |
| data_o | output | 10 | Corrected word in straight offset binary |
| data_oe_o | output | 1 | Drive enable for the tri-state wrapper |
| data_valid_o | output | 1 | High when `data_o` holds a usable word |

## Verification
The assertions assume that `pwrdn_i` and `oe_ni` are steady around each rising edge. They also assume that the stage codes follow the fixed skew of R1, so that a sample's word is meaningful only when all nine codes arrive on their own schedule. The stimulus changes every input only at falling edges. It feeds each sample through a skew scheduler that places stage k's code exactly floor((k-1)/2) steps after stage 1's code. It starts the stream of samples only after any power-down has been released. The valid-window property counts the edges since the last power-down or reset with a saturating counter, so no long delay is unrolled.

// File: rtl/pac_pkg.sv
package pac_pkg;
  localparam int unsigned STAGES  = 9;
  localparam int unsigned CODE_W  = 2;
  localparam int unsigned OUT_W   = STAGES + 1;
  localparam int unsigned LATENCY = 5;

  // cycles by which stage idx (0-based) trails stage 0
  function automatic int unsigned stage_skew(input int unsigned idx);
    return idx / 2;
  endfunction
endpackage

// File: rtl/pac_stage_align.sv
module pac_stage_align #(
  parameter int unsigned W     = 2,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] sr_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < int'(DEPTH); k++) sr_q[k] <= '0;
    end else begin
      sr_q[0] <= d_i;
      for (int k = 1; k < int'(DEPTH); k++) sr_q[k] <= sr_q[k-1];
    end
  end

  assign q_o = sr_q[DEPTH-1];
endmodule

// File: rtl/pac_overlap_sum.sv
module pac_overlap_sum
  import pac_pkg::*;
#(
  parameter int unsigned N_STG = STAGES,
  parameter int unsigned CW    = CODE_W,
  parameter int unsigned OW    = N_STG + 1
) (
  input  logic [N_STG*CW-1:0] codes_i,
  output logic [OW-1:0]       word_o
);
  localparam int unsigned SUM_W = OW + CW;
  localparam logic [SUM_W-1:0] TOP = SUM_W'((1 << OW) - 1);

  logic [SUM_W-1:0] sum;

  // stage 0 carries the largest weight; adjacent weights overlap by one bit
  always_comb begin
    sum = '0;
    for (int i = 0; i < int'(N_STG); i++) begin
      sum = sum + (SUM_W'(codes_i[i*CW +: CW]) << (N_STG - 1 - i));
    end
  end

  assign word_o = (sum > TOP) ? TOP[OW-1:0] : sum[OW-1:0];
endmodule

// File: rtl/pac_out_stage.sv
module pac_out_stage #(
  parameter int unsigned OW      = 10,
  parameter int unsigned BLANK_N = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [OW-1:0] word_i,
  input  logic          oe_ni,
  input  logic          pwrdn_i,
  output logic [OW-1:0] data_o,
  output logic          data_oe_o,
  output logic          data_valid_o
);
  localparam int unsigned CNT_W = $clog2(BLANK_N + 1);

  logic [OW-1:0]    data_q;
  logic [CNT_W-1:0] blank_q;
  logic             valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      blank_q <= CNT_W'(BLANK_N);
      valid_q <= 1'b0;
    end else begin
      data_q  <= pwrdn_i ? '0 : word_i;
      valid_q <= !pwrdn_i && (blank_q == '0);
      if (pwrdn_i)             blank_q <= CNT_W'(BLANK_N);
      else if (blank_q != '0)  blank_q <= blank_q - 1'b1;
    end
  end

  assign data_oe_o    = !oe_ni && !pwrdn_i;
  assign data_o       = data_oe_o ? data_q : '0;
  assign data_valid_o = valid_q && !pwrdn_i;
endmodule

// File: rtl/pipe_adc_corr.sv
module pipe_adc_corr
  import pac_pkg::*;
#(
  parameter int unsigned N_STG = STAGES,
  parameter int unsigned CW    = CODE_W,
  parameter int unsigned LAT   = LATENCY
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_STG*CW-1:0] stage_code_i,
  input  logic                oe_ni,
  input  logic                pwrdn_i,
  output logic [N_STG:0]      data_o,
  output logic                data_oe_o,
  output logic                data_valid_o
);
  localparam int unsigned OW       = N_STG + 1;
  localparam int unsigned MAX_SKEW = stage_skew(N_STG - 1);
  localparam int unsigned PAD      = LAT - (MAX_SKEW + 1);

  logic [N_STG*CW-1:0] aligned;
  logic [OW-1:0]       word_raw;
  logic [OW-1:0]       word_pad;

  for (genvar g = 0; g < int'(N_STG); g++) begin : g_align
    pac_stage_align #(
      .W    (CW),
      .DEPTH(MAX_SKEW - stage_skew(g) + 1)
    ) u_dly (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (stage_code_i[g*CW +: CW]),
      .q_o   (aligned[g*CW +: CW])
    );
  end

  pac_overlap_sum #(.N_STG(N_STG), .CW(CW), .OW(OW)) u_sum (
    .codes_i(aligned),
    .word_o (word_raw)
  );

  if (PAD > 0) begin : g_pad
    pac_stage_align #(.W(OW), .DEPTH(PAD)) u_pad (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (word_raw),
      .q_o   (word_pad)
    );
  end else begin : g_nopad
    assign word_pad = word_raw;
  end

  pac_out_stage #(.OW(OW), .BLANK_N(LAT)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .word_i      (word_pad),
    .oe_ni       (oe_ni),
    .pwrdn_i     (pwrdn_i),
    .data_o      (data_o),
    .data_oe_o   (data_oe_o),
    .data_valid_o(data_valid_o)
  );
endmodule

// File: rtl/pac_checker.sv
module pac_checker #(
  parameter int unsigned OW  = 10,
  parameter int unsigned LAT = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          oe_ni,
  input logic          pwrdn_i,
  input logic [OW-1:0] data_o,
  input logic          data_oe_o,
  input logic          data_valid_o
);
  localparam int unsigned SW = $clog2(LAT + 3);
  localparam logic [SW-1:0] SAT = {SW{1'b1}};

  // edges seen with power-down low since the last power-down or reset
  logic [SW-1:0] since_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             since_q <= '0;
    else if (pwrdn_i)        since_q <= '0;
    else if (since_q != SAT) since_q <= since_q + 1'b1;
  end

  a_r6_bus_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_ni || pwrdn_i) |-> (!data_oe_o && data_o == '0));

  a_r7_pd_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrdn_i |-> (!data_valid_o && !data_oe_o));

  a_r8_wake_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> (since_q >= SW'(LAT + 1)));

  a_r8_fell_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwrdn_i) |-> !data_valid_o);
endmodule

bind pipe_adc_corr pac_checker #(.OW(N_STG + 1), .LAT(LAT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .oe_ni       (oe_ni),
  .pwrdn_i     (pwrdn_i),
  .data_o      (data_o),
  .data_oe_o   (data_oe_o),
  .data_valid_o(data_valid_o)
);

// File: tb/tb_pipe_adc_corr.sv
module tb_pipe_adc_corr;
  localparam int NSTG = 9;
  localparam int NS   = 40;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [17:0] stage_code = '0;
  logic        oe_ni = 1'b0;
  logic        pwrdn = 1'b0;
  logic [9:0]  data_o;
  logic        data_oe_o;
  logic        data_valid_o;

  int ecount = 0;
  int n_chk = 0;
  int n_err = 0;

  logic [17:0] samp [NS];
  int          due_q [$];
  logic [9:0]  val_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;
  always @(posedge clk) ecount <= ecount + 1;

  pipe_adc_corr dut (
    .clk_i(clk), .rst_ni(rst_ni), .stage_code_i(stage_code),
    .oe_ni(oe_ni), .pwrdn_i(pwrdn),
    .data_o(data_o), .data_oe_o(data_oe_o), .data_valid_o(data_valid_o)
  );

  function automatic logic [9:0] ref_word(input logic [17:0] c);
    int s = 0;
    for (int i = 0; i < NSTG; i++) s += int'(c[2*i +: 2]) << (8 - i);
    if (s > 1023) s = 1023;
    return 10'(s);
  endfunction

  function automatic logic [17:0] mk(input int d [9]);
    logic [17:0] r = '0;
    for (int i = 0; i < NSTG; i++) r[2*i +: 2] = 2'(d[i]);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at edge %0d", req, act, exp, ecount);
    end
  endtask

  // monitor: pops the word due at this edge and compares it
  initial begin
    forever begin
      @(negedge clk); #1;
      while (due_q.size() > 0 && due_q[0] < ecount) begin
        check(1'b0, {tag_q[0], " missed"}, 0, int'(val_q[0]));
        void'(due_q.pop_front()); void'(val_q.pop_front()); void'(tag_q.pop_front());
      end
      if (due_q.size() > 0 && due_q[0] == ecount) begin
        if (!oe_ni && !pwrdn) begin
          check(data_o == val_q[0], tag_q[0], int'(data_o), int'(val_q[0]));
          check(data_oe_o == 1'b1, "R6 enable", int'(data_oe_o), 1);
        end else begin
          check(data_o == '0 && !data_oe_o, "R6 blanked", int'(data_o), 0);
        end
        void'(due_q.pop_front()); void'(val_q.pop_front()); void'(tag_q.pop_front());
      end
    end
  end

  // driver: skews stage k by floor((k-1)/2) steps (R1) and queues expected words (R3)
  task automatic stream(input int first, input int count, input string tag,
                        input int oe_lo, input int oe_hi);
    for (int s = 0; s < count + 4; s++) begin
      @(negedge clk);
      for (int i = 0; i < NSTG; i++) begin
        int n = s - i / 2;
        stage_code[2*i +: 2] = (n >= 0 && n < count) ? samp[first + n][2*i +: 2] : 2'b00;
      end
      oe_ni = (s >= oe_lo && s < oe_hi);
      if (s < count) begin
        due_q.push_back(ecount + 6);
        val_q.push_back(ref_word(samp[first + s]));
        tag_q.push_back(tag);
      end
    end
    @(negedge clk);
    stage_code = '0;
    oe_ni = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic valid_window(input string req);
    int k = ecount;
    while (ecount < k + 5) @(negedge clk);
    #1 check(!data_valid_o, req, int'(data_valid_o), 0);
    @(negedge clk);
    #1 check(data_valid_o, req, int'(data_valid_o), 1);
  endtask

  initial begin
    #(8 * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int d [9];
    int x = 32'h1d2c3b4a;
    for (int i = 0; i < 9; i++) d[i] = 0;
    samp[0] = mk(d);                                   // R4 zero -> 0
    d[0] = 2; samp[1] = mk(d);                         // R4 mid -> 512
    d[0] = 3; for (int i = 1; i < 9; i++) d[i] = 1;
    samp[2] = mk(d);                                   // R4 full -> 1023
    for (int i = 0; i < 9; i++) d[i] = 3;
    samp[3] = mk(d);                                   // R5 clamp
    for (int i = 0; i < 9; i++) d[i] = 0;
    d[0] = 3; d[1] = 3; samp[4] = mk(d);               // R5 1152 -> 1023
    for (int i = 0; i < 9; i++) d[i] = 0;
    d[8] = 3; samp[5] = mk(d);                         // stage 9 weight 1
    d[8] = 0; d[7] = 1; samp[6] = mk(d);               // stage 8 weight 2
    for (int n = 7; n < NS; n++) begin
      x = x ^ (x << 13); x = x ^ (x >>> 17); x = x ^ (x << 5);
      samp[n] = 18'(x);
    end

    // R9: reset state
    #1 check(data_o == '0 && !data_valid_o, "R9 reset state", int'(data_o), 0);
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    valid_window("R9 window after reset");

    check(ref_word(samp[1]) == 10'd512, "R4 mid model", int'(ref_word(samp[1])), 512);
    stream(0, 3, "R4", -1, -1);
    stream(3, 2, "R5", -1, -1);
    stream(5, 2, "R2", -1, -1);
    stream(7, 16, "R2 R1 R3", -1, -1);

    // R6/R10: bus blanked for a while mid stream
    stream(23, 10, "R10", 3, 8);

    // R7: power-down
    @(negedge clk); pwrdn = 1'b1;
    repeat (4) begin
      @(negedge clk); #1;
      check(!data_oe_o && !data_valid_o && data_o == '0, "R7 power-down",
            int'(data_oe_o) + int'(data_valid_o), 0);
    end
    @(negedge clk); pwrdn = 1'b0;
    valid_window("R8 wake window");
    stream(33, 7, "R8 data after wake", -1, -1);

    // R9: asynchronous reset mid run
    @(negedge clk); #2 rst_ni = 1'b0;
    #1 check(data_o == '0 && !data_valid_o, "R9 async reset", int'(data_o), 0);
    @(negedge clk); rst_ni = 1'b1;
    valid_window("R9 window after second reset");
    stream(0, 5, "R9 data after reset", -1, -1);

    check(due_q.size() == 0, "R3 queue drained", due_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule